// File: doc/BRIEF.md
# Register Result Status Rename Table

This block holds the architectural floating-point register file of an out-of-order core that uses reservation stations. Each register keeps a committed value and a status tag. The tag names the reservation station that will produce the register's next value. A tag of zero means no producer is pending, and in that case the stored value is current.

When an instruction issues, two source indices are looked up in the same cycle. Each source comes back either as a ready value or as the tag of the station it must wait for. The issuing station's tag is then written into the destination register's status. A newer writer therefore takes over a register that an older writer still owns, so name hazards never cause a stall.

Finished results arrive on a broadcast result bus as a tag and a value. A register accepts a broadcast only if its status holds that exact tag. When it does, it stores the value and clears the status to zero.

Top module: `rs_rename_table`

## Requirements
- R1: After reset every status tag is zero and every register reads as ready with the value RESET_VAL (default 0).
- R2: A source whose status is zero is returned with its ready flag at 1, its value output equal to the stored value, and its tag output at 0. This happens in the same cycle, combinationally.
- R3: A source whose status is non-zero, with no matching broadcast, is returned with its ready flag at 0, its value output at 0, and its tag output equal to the stored status.
- R4: An issue with the destination enable set writes the issue tag into the destination's status on the next clock edge. This holds even when another tag is already there.
- R5: A valid broadcast whose tag equals a register's non-zero status stores the broadcast value in that register and clears its status on the next edge.
- R6: A broadcast whose tag differs from a register's status changes neither the status nor the value of that register, so an older writer cannot overwrite the result of a newer one.
- R7: If a source is looked up in the same cycle that its producer broadcasts, the broadcast value is returned with the ready flag at 1 and the tag output at 0.
- R8: If an issue targets a register in the same cycle that a broadcast would clear it, the new issue tag is what remains in the status. The broadcast value is still written into the committed value.
- R9: An issue with the destination enable at 0 leaves every status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | An instruction issues this cycle |
| iss_src_a_i | input | IDX_W | First source register index |
| iss_src_b_i | input | IDX_W | Second source register index |
| iss_dst_en_i | input | 1 | Instruction writes a destination register |
| iss_dst_i | input | IDX_W | Destination register index |
| iss_tag_i | input | TAG_W | Tag of the issuing station, non-zero |
| cdb_valid_i | input | 1 | Broadcast valid |
| cdb_tag_i | input | TAG_W | Tag of the station broadcasting, non-zero |
| cdb_data_i | input | DATA_W | Broadcast result value |
| opa_rdy_o | output | 1 | First source is ready |
| opa_val_o | output | DATA_W | First source value (0 when not ready) |
| opa_tag_o | output | TAG_W | First source producer tag (0 when ready) |
| opb_rdy_o | output | 1 | Second source is ready |
| opb_val_o | output | DATA_W | Second source value (0 when not ready) |
| opb_tag_o | output | TAG_W | Second source producer tag (0 when ready) |

## Verification
The assertions assume three things about the inputs. Issue and broadcast tags are never zero. A station tag is not handed out again while a register still lists it as pending. At most one broadcast happens per cycle. The stimulus follows these rules by giving every issue a station tag that is free at that point and by broadcasting only tags that were issued earlier, each one a single time. The tag-zero path is reached only through reset.

// File: rtl/rs_rename_pkg.sv
package rs_rename_pkg;
    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_TAG_W    = 3;
endpackage

// File: rtl/rs_rename_entry.sv
// Next-state logic for one register: status tag and committed value.
module rs_rename_entry #(
    parameter int DATA_W = rs_rename_pkg::DEF_DATA_W,
    parameter int TAG_W  = rs_rename_pkg::DEF_TAG_W
) (
    input  logic [TAG_W-1:0]  cur_tag_i,
    input  logic [DATA_W-1:0] cur_val_i,
    input  logic              iss_hit_i,
    input  logic [TAG_W-1:0]  iss_tag_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_data_i,
    output logic [TAG_W-1:0]  nxt_tag_o,
    output logic [DATA_W-1:0] nxt_val_o
);
    logic bcast_hit;

    always_comb begin
        bcast_hit = cdb_valid_i && (cur_tag_i != '0) && (cur_tag_i == cdb_tag_i);
        nxt_tag_o = cur_tag_i;
        nxt_val_o = cur_val_i;
        if (bcast_hit) begin
            nxt_val_o = cdb_data_i;
            nxt_tag_o = '0;
        end
        // a fresh issue overrides the clear from the broadcast
        if (iss_hit_i) begin
            nxt_tag_o = iss_tag_i;
        end
    end
endmodule

// File: rtl/rs_rename_lookup.sv
// Source operand lookup with same-cycle broadcast forwarding.
module rs_rename_lookup #(
    parameter int DATA_W = rs_rename_pkg::DEF_DATA_W,
    parameter int TAG_W  = rs_rename_pkg::DEF_TAG_W
) (
    input  logic [TAG_W-1:0]  ent_tag_i,
    input  logic [DATA_W-1:0] ent_val_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_data_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] val_o,
    output logic [TAG_W-1:0]  tag_o
);
    always_comb begin
        rdy_o = 1'b0;
        val_o = '0;
        tag_o = ent_tag_i;
        if (ent_tag_i == '0) begin
            rdy_o = 1'b1;
            val_o = ent_val_i;
        end else if (cdb_valid_i && (cdb_tag_i == ent_tag_i)) begin
            rdy_o = 1'b1;
            val_o = cdb_data_i;
            tag_o = '0;
        end
    end
endmodule

// File: rtl/rs_rename_table.sv
module rs_rename_table #(
    parameter int                     NUM_REGS  = rs_rename_pkg::DEF_NUM_REGS,
    parameter int                     DATA_W    = rs_rename_pkg::DEF_DATA_W,
    parameter int                     TAG_W     = rs_rename_pkg::DEF_TAG_W,
    parameter logic [DATA_W-1:0]      RESET_VAL = '0,
    localparam int                    IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              iss_valid_i,
    input  logic [IDX_W-1:0]  iss_src_a_i,
    input  logic [IDX_W-1:0]  iss_src_b_i,
    input  logic              iss_dst_en_i,
    input  logic [IDX_W-1:0]  iss_dst_i,
    input  logic [TAG_W-1:0]  iss_tag_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_data_i,
    output logic              opa_rdy_o,
    output logic [DATA_W-1:0] opa_val_o,
    output logic [TAG_W-1:0]  opa_tag_o,
    output logic              opb_rdy_o,
    output logic [DATA_W-1:0] opb_val_o,
    output logic [TAG_W-1:0]  opb_tag_o
);
    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_REGS-1:0] ent;
    } state_t;

    state_t                          state_d, state_q;
    entry_t [NUM_REGS-1:0]           ent_nxt;
    logic   [NUM_REGS-1:0][TAG_W-1:0] tag_vec;

    logic [IDX_W-1:0]  src_idx [NUM_SRC];
    logic              src_rdy [NUM_SRC];
    logic [DATA_W-1:0] src_val [NUM_SRC];
    logic [TAG_W-1:0]  src_tag [NUM_SRC];

    assign src_idx[0] = iss_src_a_i;
    assign src_idx[1] = iss_src_b_i;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
        rs_rename_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
            .cur_tag_i  (state_q.ent[r].tag),
            .cur_val_i  (state_q.ent[r].val),
            .iss_hit_i  (iss_valid_i && iss_dst_en_i && (iss_dst_i == IDX_W'(r))),
            .iss_tag_i  (iss_tag_i),
            .cdb_valid_i(cdb_valid_i),
            .cdb_tag_i  (cdb_tag_i),
            .cdb_data_i (cdb_data_i),
            .nxt_tag_o  (ent_nxt[r].tag),
            .nxt_val_o  (ent_nxt[r].val)
        );
        assign tag_vec[r] = state_q.ent[r].tag;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rs_rename_lookup #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_lkp (
            .ent_tag_i  (state_q.ent[src_idx[s]].tag),
            .ent_val_i  (state_q.ent[src_idx[s]].val),
            .cdb_valid_i(cdb_valid_i),
            .cdb_tag_i  (cdb_tag_i),
            .cdb_data_i (cdb_data_i),
            .rdy_o      (src_rdy[s]),
            .val_o      (src_val[s]),
            .tag_o      (src_tag[s])
        );
    end

    assign opa_rdy_o = src_rdy[0];
    assign opa_val_o = src_val[0];
    assign opa_tag_o = src_tag[0];
    assign opb_rdy_o = src_rdy[1];
    assign opb_val_o = src_val[1];
    assign opb_tag_o = src_tag[1];

    always_comb begin
        state_d     = state_q;
        state_d.ent = ent_nxt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                state_q.ent[r].tag <= '0;
                state_q.ent[r].val <= RESET_VAL;
            end
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/rs_rename_chk.sv
module rs_rename_chk #(
    parameter int NUM_REGS = rs_rename_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rs_rename_pkg::DEF_DATA_W,
    parameter int TAG_W    = rs_rename_pkg::DEF_TAG_W,
    parameter int IDX_W    = 3
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          iss_valid_i,
    input logic                          iss_dst_en_i,
    input logic [IDX_W-1:0]              iss_dst_i,
    input logic [TAG_W-1:0]              iss_tag_i,
    input logic [IDX_W-1:0]              iss_src_a_i,
    input logic                          cdb_valid_i,
    input logic [TAG_W-1:0]              cdb_tag_i,
    input logic [DATA_W-1:0]             cdb_data_i,
    input logic                          opa_rdy_o,
    input logic [DATA_W-1:0]             opa_val_o,
    input logic [TAG_W-1:0]              opa_tag_o,
    input logic                          opb_rdy_o,
    input logic [TAG_W-1:0]              opb_tag_o,
    input logic [NUM_REGS-1:0][TAG_W-1:0] tag_vec
);
    AST_READY_A_NO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        opa_rdy_o |-> (opa_tag_o == '0)); // R2
    AST_READY_B_NO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        opb_rdy_o |-> (opb_tag_o == '0)); // R2
    AST_PENDING_A_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !opa_rdy_o |-> (opa_tag_o != '0) && (opa_val_o == '0)); // R3
    AST_FORWARD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cdb_valid_i && cdb_tag_i != '0 && tag_vec[iss_src_a_i] == cdb_tag_i)
        |-> (opa_rdy_o && opa_val_o == cdb_data_i)); // R7
    AST_ISSUE_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_valid_i && iss_dst_en_i) |=> (tag_vec[$past(iss_dst_i)] == $past(iss_tag_i))); // R4

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        AST_BCAST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cdb_valid_i && tag_vec[r] != '0 && tag_vec[r] == cdb_tag_i
             && !(iss_valid_i && iss_dst_en_i && iss_dst_i == IDX_W'(r)))
            |=> (tag_vec[r] == '0)); // R5
        AST_TAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!(iss_valid_i && iss_dst_en_i && iss_dst_i == IDX_W'(r))
             && !(cdb_valid_i && tag_vec[r] == cdb_tag_i))
            |=> $stable(tag_vec[r])); // R6
    end
endmodule

bind rs_rename_table rs_rename_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .iss_valid_i (iss_valid_i),
    .iss_dst_en_i(iss_dst_en_i),
    .iss_dst_i   (iss_dst_i),
    .iss_tag_i   (iss_tag_i),
    .iss_src_a_i (iss_src_a_i),
    .cdb_valid_i (cdb_valid_i),
    .cdb_tag_i   (cdb_tag_i),
    .cdb_data_i  (cdb_data_i),
    .opa_rdy_o   (opa_rdy_o),
    .opa_val_o   (opa_val_o),
    .opa_tag_o   (opa_tag_o),
    .opb_rdy_o   (opb_rdy_o),
    .opb_tag_o   (opb_tag_o),
    .tag_vec     (tag_vec)
);

// File: tb/rs_rename_table_tb.sv
`timescale 1ns/1ps
module rs_rename_table_tb_top;
    localparam int NR = 8;
    localparam int DW = 32;
    localparam int TW = 3;
    localparam int IW = 3;
    localparam int NV = 12;

    typedef struct packed {
        logic          iv;
        logic [IW-1:0] sa;
        logic [IW-1:0] sb;
        logic          den;
        logic [IW-1:0] dst;
        logic [TW-1:0] itag;
        logic          cv;
        logic [TW-1:0] ctag;
        logic [DW-1:0] cdata;
        logic          ardy;
        logic [DW-1:0] aval;
        logic [TW-1:0] atag;
        logic          brdy;
        logic [DW-1:0] bval;
        logic [TW-1:0] btag;
    } vec_t;

    // iv sa sb den dst itag | cv ctag cdata | a: rdy val tag | b: rdy val tag
    localparam vec_t VECS [NV] = '{
        '{1, 0, 1, 1, 2, 1, 0, 0, 32'h00, 1, 32'h00, 0, 1, 32'h00, 0},
        '{1, 2, 1, 1, 3, 2, 0, 0, 32'h00, 0, 32'h00, 1, 1, 32'h00, 0},
        '{1, 3, 2, 1, 2, 3, 0, 0, 32'h00, 0, 32'h00, 2, 0, 32'h00, 1},
        '{0, 2, 3, 0, 0, 0, 1, 1, 32'h11, 0, 32'h00, 3, 0, 32'h00, 2},
        '{0, 2, 3, 0, 0, 0, 1, 2, 32'h22, 0, 32'h00, 3, 1, 32'h22, 0},
        '{1, 3, 2, 1, 3, 4, 1, 3, 32'h33, 1, 32'h22, 0, 1, 32'h33, 0},
        '{1, 3, 2, 1, 3, 5, 1, 4, 32'h44, 1, 32'h44, 0, 1, 32'h33, 0},
        '{0, 3, 2, 0, 0, 0, 0, 0, 32'h00, 0, 32'h00, 5, 1, 32'h33, 0},
        '{1, 2, 0, 0, 2, 6, 0, 0, 32'h00, 1, 32'h33, 0, 1, 32'h00, 0},
        '{0, 2, 3, 0, 0, 0, 0, 0, 32'h00, 1, 32'h33, 0, 0, 32'h00, 5},
        '{0, 3, 3, 0, 0, 0, 1, 5, 32'h55, 1, 32'h55, 0, 1, 32'h55, 0},
        '{0, 3, 2, 0, 0, 0, 0, 0, 32'h00, 1, 32'h55, 0, 1, 32'h33, 0}
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R2 R4";
            1: return "R3 R4";
            2: return "R3 R4 (second writer)";
            3: return "R6 R3";
            4: return "R7 R5";
            5: return "R7 R5 R2";
            6: return "R8 R7";
            7: return "R8";
            8: return "R9 R2";
            9: return "R9";
            10: return "R7 R5";
            default: return "R5 R8";
        endcase
    endfunction

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          iss_valid_i = 1'b0;
    logic [IW-1:0] iss_src_a_i = '0;
    logic [IW-1:0] iss_src_b_i = '0;
    logic          iss_dst_en_i = 1'b0;
    logic [IW-1:0] iss_dst_i = '0;
    logic [TW-1:0] iss_tag_i = '0;
    logic          cdb_valid_i = 1'b0;
    logic [TW-1:0] cdb_tag_i = '0;
    logic [DW-1:0] cdb_data_i = '0;
    logic          opa_rdy_o, opb_rdy_o;
    logic [DW-1:0] opa_val_o, opb_val_o;
    logic [TW-1:0] opa_tag_o, opb_tag_o;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #5 clk_i = ~clk_i;

    rs_rename_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .RESET_VAL('0)) dut_i (
        .clk_i, .rst_ni, .iss_valid_i, .iss_src_a_i, .iss_src_b_i, .iss_dst_en_i,
        .iss_dst_i, .iss_tag_i, .cdb_valid_i, .cdb_tag_i, .cdb_data_i,
        .opa_rdy_o, .opa_val_o, .opa_tag_o, .opb_rdy_o, .opb_val_o, .opb_tag_o
    );

    task automatic check_src(string req, string port, logic rdy, logic [DW-1:0] val,
                             logic [TW-1:0] tag, logic erdy, logic [DW-1:0] eval,
                             logic [TW-1:0] etag);
        n_checks++;
        if (rdy !== erdy || val !== eval || tag !== etag) begin
            n_errs++;
            $display("FAIL %s port %s: actual rdy=%0b val=%h tag=%0d expected rdy=%0b val=%h tag=%0d",
                     req, port, rdy, val, tag, erdy, eval, etag);
        end
    endtask

    task automatic idle_inputs();
        iss_valid_i  = 1'b0;
        iss_dst_en_i = 1'b0;
        iss_dst_i    = '0;
        iss_tag_i    = '0;
        cdb_valid_i  = 1'b0;
        cdb_tag_i    = '0;
        cdb_data_i   = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R1: every register ready with the reset constant
        for (int r = 0; r < NR; r += 2) begin
            iss_src_a_i = IW'(r);
            iss_src_b_i = IW'(r + 1);
            #2;
            check_src("R1", "a", opa_rdy_o, opa_val_o, opa_tag_o, 1'b1, '0, '0);
            check_src("R1", "b", opb_rdy_o, opb_val_o, opb_tag_o, 1'b1, '0, '0);
            @(negedge clk_i);
        end

        // Vector walk: drive after the falling edge, sample the combinational reads 2 ns later.
        for (int i = 0; i < NV; i++) begin
            iss_valid_i  = VECS[i].iv;
            iss_src_a_i  = VECS[i].sa;
            iss_src_b_i  = VECS[i].sb;
            iss_dst_en_i = VECS[i].den;
            iss_dst_i    = VECS[i].dst;
            iss_tag_i    = VECS[i].itag;
            cdb_valid_i  = VECS[i].cv;
            cdb_tag_i    = VECS[i].ctag;
            cdb_data_i   = VECS[i].cdata;
            #2;
            check_src(vec_req(i), "a", opa_rdy_o, opa_val_o, opa_tag_o,
                      VECS[i].ardy, VECS[i].aval, VECS[i].atag);
            check_src(vec_req(i), "b", opb_rdy_o, opb_val_o, opb_tag_o,
                      VECS[i].brdy, VECS[i].bval, VECS[i].btag);
            @(negedge clk_i);
        end
        idle_inputs();

        // R8: register 3 took 0x44 while being re-tagged, then 0x55 on its own broadcast
        iss_src_a_i = 3'd3;
        iss_src_b_i = 3'd0;
        #2;
        check_src("R8 value", "a", opa_rdy_o, opa_val_o, opa_tag_o, 1'b1, 32'h55, '0);
        @(negedge clk_i);

        // R6: a broadcast of an unowned tag changes nothing
        iss_valid_i = 1'b1; iss_dst_en_i = 1'b1; iss_dst_i = 3'd5; iss_tag_i = 3'd7;
        @(negedge clk_i);
        idle_inputs();
        cdb_valid_i = 1'b1; cdb_tag_i = 3'd6; cdb_data_i = 32'hDEAD;
        @(negedge clk_i);
        idle_inputs();
        iss_src_a_i = 3'd5;
        iss_src_b_i = 3'd4;
        #2;
        check_src("R6", "a", opa_rdy_o, opa_val_o, opa_tag_o, 1'b0, '0, 3'd7);
        check_src("R6", "b", opb_rdy_o, opb_val_o, opb_tag_o, 1'b1, '0, '0);
        @(negedge clk_i);

        // R1: a second reset clears the pending tag and every stored value
        rst_ni = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        iss_src_a_i = 3'd5;
        iss_src_b_i = 3'd2;
        #2;
        check_src("R1 rerun", "a", opa_rdy_o, opa_val_o, opa_tag_o, 1'b1, '0, '0);
        check_src("R1 rerun", "b", opb_rdy_o, opb_val_o, opb_tag_o, 1'b1, '0, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk_i);
                n_checks++;
                n_errs++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule